// File: doc/BRIEF.md
# Word Serializer with Internal Wrap Path

This block turns a stream of 20-bit parallel words into a single serial bit stream. It runs entirely on the bit clock. An internal divide-by-20 counter plays the part of the word clock and raises a one-cycle strobe in the cycle where the next word is taken from the parallel input. Each captured word is then shifted out one bit per bit-clock cycle, lowest bit first. A word holds two 10-bit already-encoded characters, with the lower half sent first. No encoding is done here.

A wrap control chooses where the serial stream goes. With wrap low, the stream drives the differential line output and the loopback output stays low. With wrap high, the stream goes to the loopback output, which feeds an on-chip receiver. The line output is then parked with the true leg high and the complement leg low. Wrap only selects the path. It never stalls or re-times the shift register, so it may change at any cycle.

Top module: `ser_loop_tx`

## Requirements
- R1: `word_tick_o` is high in exactly one cycle out of every 20. After reset is released it is first high in the 20th cycle, counting the release cycle as the first. The value on `data_i` in a tick cycle is the word that gets captured.
- R2: After a word is captured, its bit k appears on the serial stream in the k-th cycle after the capture edge (k = 0..19). Bit 0 comes out in the cycle right after the capture edge, and the next word follows without a gap.
- R3: The word carries two 10-bit characters: the first in bits 0..9 and the second in bits 10..19. The first character goes out whole, lowest bit first, before any bit of the second.
- R4: While `wrap_i` is 1, `line_p_o` is 1 and `line_n_o` is 0, whatever the data.
- R5: While `wrap_i` is 1, `loop_o` carries the serial stream with the timing of R2.
- R6: While `wrap_i` is 0, `line_p_o` carries the serial stream with the timing of R2, and `loop_o` is 0.
- R7: `line_n_o` is always the inverse of `line_p_o`.
- R8: A synchronous active-low reset clears the shift register. From reset until the first word has been captured, the serial stream is 0, so `line_p_o` is 0 with wrap low and `loop_o` is 0.
- R9: Changing `wrap_i` in the middle of a word only moves the remaining bits to the other output. It neither drops nor delays them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 20 | Parallel word (two 10-bit characters), sampled when `word_tick_o` is high |
| wrap_i | input | 1 | 1 routes the stream to `loop_o` and parks the line output |
| word_tick_o | output | 1 | One-cycle word strobe, the derived word clock |
| line_p_o | output | 1 | Serial line output, true leg |
| line_n_o | output | 1 | Serial line output, complement leg |
| loop_o | output | 1 | Internal loopback serial output toward the receiver |

## Verification
The bench reads `word_tick_o` at a falling edge. The word on `data_i` is captured at the next rising edge, and bit k is due at the falling edge k+1 cycles after that strobe sample. The routing outputs follow `wrap_i` within the same cycle, so every check of a serial bit or a parked level is taken one nanosecond after the falling edge at which wrap was set. The strobe is due 19 falling edges after the one where reset is released, and every 20 after that. The bench derives each of these positions by counting, and it scrambles `data_i` after each capture to show that only the strobe-cycle value is used.

// File: rtl/ser_loop_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the word serializer.
// Assumes: characters are already line-encoded by the sender.
package ser_loop_pkg;
    localparam int unsigned DEF_CHAR_W = 10;
    localparam int unsigned DEF_CHARS  = 2;

    // Destination of the serial stream.
    typedef enum logic {
        ROUTE_LINE = 1'b0,
        ROUTE_WRAP = 1'b1
    } route_e;
endpackage

// File: rtl/ser_word_timer.sv
`timescale 1ns/1ps
// Divide-by-WORD_W counter that stands in for the word clock.
// Raises tick_o in the last bit slot of each word period.
// Assumes: WORD_W >= 2; all logic is on the bit clock.
module ser_word_timer #(
    parameter int unsigned WORD_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count bit slots within one word period, wrapping at WORD_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R1: the counter never leaves its period.
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R1: the strobe never lasts two cycles.
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ser_shift_reg.sv
`timescale 1ns/1ps
// Load-and-shift register: captures a word on load_i and shifts it
// right once per cycle, presenting bit 0 first on bit_o.
// Assumes: load_i pulses once every WORD_W cycles.
module ser_shift_reg #(
    parameter int unsigned WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              bit_o,
    output logic              valid_o
);
    logic [WORD_W-1:0] sreg_q;
    logic              valid_q;

    // Take a new word on load, otherwise move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= data_i;
        end else begin
            sreg_q <= sreg_q >> 1;
        end
    end

    // Remember whether any word has been taken since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
        end
    end

    assign bit_o   = sreg_q[0];
    assign valid_o = valid_q;

    // R2: a load places the presented word in the register.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> sreg_q == $past(data_i));
    // R2: between loads the register moves by exactly one bit.
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && valid_q) |=> sreg_q == ($past(sreg_q) >> 1));
    // R8: before the first capture the stream is quiet.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> !bit_o);
endmodule

// File: rtl/ser_route.sv
`timescale 1ns/1ps
// Steers the serial bit either to the differential line or to the
// internal loopback output; parks the line high while wrapped.
// Assumes: wrap_i may change in any cycle.
module ser_route
    import ser_loop_pkg::*;
(
    input  logic wrap_i,
    input  logic bit_i,
    output logic line_p_o,
    output logic line_n_o,
    output logic loop_o
);
    route_e route;

    // Decode the wrap control into a destination.
    always_comb begin
        route = wrap_i ? ROUTE_WRAP : ROUTE_LINE;
    end

    // Drive each destination according to the chosen route.
    always_comb begin
        unique case (route)
            ROUTE_WRAP: begin
                line_p_o = 1'b1;
                loop_o   = bit_i;
            end
            default: begin
                line_p_o = bit_i;
                loop_o   = 1'b0;
            end
        endcase
        line_n_o = ~line_p_o;
    end
endmodule

// File: rtl/ser_loop_tx.sv
`timescale 1ns/1ps
// Word serializer with internal wrap path. Captures CHARS characters
// of CHAR_W bits once per word period and sends them lowest bit first.
// Assumes: one clock domain (bit clock); word clock is a derived strobe.
module ser_loop_tx
    import ser_loop_pkg::*;
#(
    parameter int unsigned CHAR_W = DEF_CHAR_W,
    parameter int unsigned CHARS  = DEF_CHARS,
    localparam int unsigned WORD_W = CHAR_W * CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_i,
    input  logic              wrap_i,
    output logic              word_tick_o,
    output logic              line_p_o,
    output logic              line_n_o,
    output logic              loop_o
);
    logic tick;
    logic ser_bit;
    logic ser_valid;

    ser_word_timer #(.WORD_W(WORD_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ser_shift_reg #(.WORD_W(WORD_W)) shreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tick),
        .data_i  (data_i),
        .bit_o   (ser_bit),
        .valid_o (ser_valid)
    );

    ser_route route_i (
        .wrap_i   (wrap_i),
        .bit_i    (ser_bit),
        .line_p_o (line_p_o),
        .line_n_o (line_n_o),
        .loop_o   (loop_o)
    );

    assign word_tick_o = tick;

    // R4: wrap parks the line with the true leg high.
    p_wrap_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |-> (line_p_o && !line_n_o));
    // R5: wrap carries the shifted bit to the loopback output.
    p_loop_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |-> (loop_o == ser_bit));
    // R6: normal mode sends the shifted bit on the line, loopback idle.
    p_line_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |-> ((line_p_o == ser_bit) && !loop_o));
    // R7: the two line legs always disagree.
    p_complement_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_n_o != line_p_o);
    // R8: no stream bit before the first capture, on either output.
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> (!loop_o && (wrap_i || !line_p_o)));
endmodule

// File: tb/ser_loop_tx_tb_top.sv
`timescale 1ns/1ps
module ser_loop_tx_tb_top;
    localparam int CHAR_W = 10;
    localparam int CHARS  = 2;
    localparam int WORD_W = CHAR_W * CHARS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] data_i = '0;
    logic              wrap_i = 1'b0;
    logic              word_tick_o, line_p_o, line_n_o, loop_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ser_loop_tx #(.CHAR_W(CHAR_W), .CHARS(CHARS)) dut_i (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .wrap_i(wrap_i),
        .word_tick_o(word_tick_o), .line_p_o(line_p_o),
        .line_n_o(line_n_o), .loop_o(loop_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_legs();
        logic inv;
        inv = ~line_p_o;
        chk("R7 complement leg", 32'(line_n_o), 32'(inv));
    endtask

    // Reset, then check the quiet period and the first strobe position.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WORD_W; i++) begin
            wrap_i = (i >= 10);
            #1;
            chk("R1 first tick position", 32'(word_tick_o), 32'(i == WORD_W - 1));
            if (wrap_i) chk("R4 parked during quiet", 32'(line_p_o), 32'd1);
            else        chk("R8 line quiet after reset", 32'(line_p_o), 32'd0);
            chk("R8 loop quiet after reset", 32'(loop_o), 32'd0);
            check_legs();
            if (i < WORD_W - 1) @(negedge clk);
        end
    endtask

    // Present one word, follow its 20 bit slots, wrap set per character.
    task automatic run_word(input logic [WORD_W-1:0] w, input logic wa, input logic wb);
        logic [WORD_W-1:0] rx;
        logic              exp_bit;
        string             tag;
        rx = '0;
        data_i = w;
        while (!word_tick_o) @(negedge clk);
        for (int k = 0; k < WORD_W; k++) begin
            @(negedge clk);
            wrap_i = (k < CHAR_W) ? wa : wb;
            data_i = ~w;
            #1;
            exp_bit = w[k];
            chk("R1 tick period", 32'(word_tick_o), 32'(k == WORD_W - 1));
            if (wrap_i) begin
                tag = (k >= CHAR_W && wa != wb) ? "R9 loop bit after switch" : "R5 loop bit";
                chk("R4 line parked", 32'(line_p_o), 32'd1);
                chk(tag, 32'(loop_o), 32'(exp_bit));
                rx[k] = loop_o;
            end else begin
                tag = (k >= CHAR_W && wa != wb) ? "R9 line bit after switch" : "R6 line bit";
                chk(tag, 32'(line_p_o), 32'(exp_bit));
                chk("R6 loop idle", 32'(loop_o), 32'd0);
                rx[k] = line_p_o;
            end
            check_legs();
        end
        chk("R2 whole word order", 32'(rx), 32'(w));
        chk("R3 first char", 32'(rx[CHAR_W-1:0]), 32'(w[CHAR_W-1:0]));
        chk("R3 second char", 32'(rx[WORD_W-1:CHAR_W]), 32'(w[WORD_W-1:CHAR_W]));
    endtask

    initial begin
        logic [CHAR_W-1:0] chars [5];
        chars[0] = 10'h283; chars[1] = 10'h17C; chars[2] = 10'h3FF;
        chars[3] = 10'h000; chars[4] = 10'h155;
        do_reset();
        run_word('0, 1'b0, 1'b0);
        run_word('1, 1'b0, 1'b0);
        run_word(20'hAAAAA, 1'b1, 1'b1);
        run_word(20'h55555, 1'b1, 1'b1);
        for (int i = 0; i < WORD_W; i++)
            run_word(WORD_W'(1) << i, i[0], i[1]);
        for (int i = 0; i < WORD_W; i++)
            run_word(~(WORD_W'(1) << i), i[1], i[0]);
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                run_word({chars[b], chars[a]}, (a + b) % 2 == 1, (a + b) % 4 >= 2);
        // Reset in the middle of a word, then resume.
        data_i = 20'h0F0F3;
        while (!word_tick_o) @(negedge clk);
        repeat (7) @(negedge clk);
        do_reset();
        run_word(20'hC3A5E, 1'b0, 1'b1);
        run_word(20'h1B2C4, 1'b1, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule